// File: doc/BRIEF.md
# Per-Cell Charge Tracker by Current Integration

This block holds a running state-of-charge figure for each of the K series cells of one module. It is fed with only two measured currents: the string current that flows through the whole chain, and the current of the balancing converter. At any moment at most one cell is bypassed and connected to the converter. From that selection the block works out what every cell is carrying. The selected cell carries the converter current with its sign reversed. Every other cell carries the string current, plus its share of the converter current after converter losses, plus a module-level balancing term.

On each valid sample, every cell's current is scaled by a fixed gain that stands for the sample period divided by the cell capacity. The result is taken off a fixed-point accumulator that saturates between empty and full. Positive string current means discharge, so positive cell current lowers the stored charge. Software-independent start values are written into the accumulators through a small write port while an init signal is held high. Accumulation is suspended for the whole time init is high.

Top module: `cct_tracker`

## Requirements
- R1: While rst_i is high, every state-of-charge output is 0. They are still 0 in the first cycle after reset is released.
- R2: While init_i and wr_en_i are both high, the clock edge loads wr_data_i into cell wr_idx_i. Its hidden FRAC_W fraction bits are cleared. All other cells keep their values.
- R3: While init_i is high, sample_vld_i has no effect, whatever the currents are.
- R4: When sample_vld_i is low, all state-of-charge outputs hold their values.
- R5: For the cell whose index equals sel_i, the cell current is minus i_bal_i.
- R6: When sel_i is below K, each non-selected cell current is i_string_i + share + i_mod_i. Here share = (i_bal_i × eff_i × RECIP) / 2^(EFF_W+RF), rounded toward zero, with RECIP = floor(2^RF / (K−1)). eff_i is unsigned, so efficiency equals eff_i/256.
- R7: When sel_i is K or larger, no cell is selected, and every cell current is i_string_i + i_mod_i.
- R8: On each accepted sample, every cell accumulator (SOC_W+FRAC_W bits, output = upper SOC_W bits) decreases by cell current × CAP_GAIN. Positive current means discharge.
- R9: An update that would go below 0 leaves the accumulator at 0.
- R10: An update that would pass full scale leaves the accumulator at all ones, so the output reads 2^SOC_W − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| init_i | input | 1 | Init phase: enables writes, suspends accumulation |
| wr_en_i | input | 1 | Write strobe for a start value |
| wr_idx_i | input | $clog2(K) | Cell addressed by the write |
| wr_data_i | input | SOC_W | Start value for the addressed cell |
| sample_vld_i | input | 1 | A new current sample set is present |
| i_string_i | input | CUR_W | Signed string current, positive when discharging |
| i_bal_i | input | CUR_W | Signed balancing-converter current |
| i_mod_i | input | CUR_W | Signed module-level balancing current |
| sel_i | input | $clog2(K)+1 | Index of the bypassed cell; K or more means none |
| eff_i | input | EFF_W | Converter efficiency, unsigned, value/256 |
| soc_o | output | K×SOC_W | State of charge per cell, cell 0 in the low bits |

## Verification
The hardest condition to reach is saturation at the two rails. It needs a cell near empty or near full together with a large current of the correct sign, and integration from mid-scale would take thousands of samples. The stimulus uses the init write port to place every cell a few hundred counts from a rail. It then applies one full-scale sample, so a single update overshoots and the clamp must act. A second hard case is the rounding toward zero of the shared converter current. Vectors with a negative converter current and a non-power-of-two efficiency expose the difference between truncation and a plain arithmetic shift.

// File: rtl/cct_pkg.sv
package cct_pkg;
    typedef enum logic [1:0] {
        SRC_BYPASSED = 2'd0,
        SRC_IN_STRING = 2'd1,
        SRC_NO_SELECT = 2'd2
    } cell_src_e;
endpackage

// File: rtl/cct_share.sv
module cct_share #(
    parameter int K     = 4,
    parameter int CUR_W = 12,
    parameter int EFF_W = 8,
    parameter int RF    = 10
) (
    input  logic signed [CUR_W-1:0] i_bal_i,
    input  logic        [EFF_W-1:0] eff_i,
    output logic signed [CUR_W:0]   share_o
);
    localparam int RECIP = (1 << RF) / (K - 1);
    localparam int SH    = EFF_W + RF;
    localparam int PW    = CUR_W + EFF_W + RF + 4;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] biased;
    logic signed [PW-1:0] scaled;

    always_comb begin
        prod   = PW'(i_bal_i) * PW'($signed({1'b0, eff_i})) * PW'(RECIP);
        biased = prod[PW-1] ? prod + PW'((1 << SH) - 1) : prod;
        scaled = biased >>> SH;
        share_o = (CUR_W+1)'(scaled);
    end
endmodule

// File: rtl/cct_cell_cur.sv
module cct_cell_cur
    import cct_pkg::*;
#(
    parameter int K     = 4,
    parameter int CUR_W = 12,
    parameter int SEL_W = 3,
    parameter int IC_W  = 15
) (
    input  logic signed [CUR_W-1:0] i_string_i,
    input  logic signed [CUR_W-1:0] i_bal_i,
    input  logic signed [CUR_W-1:0] i_mod_i,
    input  logic signed [CUR_W:0]   share_i,
    input  logic        [SEL_W-1:0] sel_i,
    output logic        [K*IC_W-1:0] icur_o
);
    logic sel_ok;
    assign sel_ok = (sel_i < SEL_W'(K));

    for (genvar g = 0; g < K; g++) begin : g_cell
        cell_src_e src;
        logic signed [IC_W-1:0] cur;
        always_comb begin
            if (!sel_ok)                   src = SRC_NO_SELECT;
            else if (sel_i == SEL_W'(g))   src = SRC_BYPASSED;
            else                           src = SRC_IN_STRING;
            case (src)
                SRC_BYPASSED:  cur = -IC_W'(i_bal_i);
                SRC_IN_STRING: cur = IC_W'(i_string_i) + IC_W'(share_i) + IC_W'(i_mod_i);
                default:       cur = IC_W'(i_string_i) + IC_W'(i_mod_i);
            endcase
        end
        assign icur_o[g*IC_W +: IC_W] = cur;
    end
endmodule

// File: rtl/cct_soc_reg.sv
module cct_soc_reg #(
    parameter int IC_W     = 15,
    parameter int SOC_W    = 16,
    parameter int FRAC_W   = 8,
    parameter int GAIN_W   = 16,
    parameter int CAP_GAIN = 64
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   load_i,
    input  logic [SOC_W-1:0]       load_data_i,
    input  logic                   step_i,
    input  logic signed [IC_W-1:0] icur_i,
    output logic [SOC_W-1:0]       soc_o
);
    localparam int ACC_W = SOC_W + FRAC_W;
    localparam int DW    = ACC_W + IC_W + GAIN_W + 2;
    localparam logic [GAIN_W-1:0] GAIN = GAIN_W'(CAP_GAIN);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } soc_st_t;

    soc_st_t st_d, st_q;
    logic signed [DW-1:0] delta, cand;

    always_comb begin
        st_d  = st_q;
        delta = DW'(icur_i) * DW'($signed({1'b0, GAIN}));
        cand  = $signed({{(DW-ACC_W){1'b0}}, st_q.acc}) - delta;
        if (load_i) begin
            st_d.acc = {load_data_i, {FRAC_W{1'b0}}};
        end else if (step_i) begin
            if (cand < 0)
                st_d.acc = '0;
            else if (cand > $signed({{(DW-ACC_W){1'b0}}, {ACC_W{1'b1}}}))
                st_d.acc = '1;
            else
                st_d.acc = ACC_W'(cand);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign soc_o = st_q.acc[ACC_W-1 -: SOC_W];
endmodule

// File: rtl/cct_tracker.sv
module cct_tracker #(
    parameter int K        = 4,
    parameter int CUR_W    = 12,
    parameter int EFF_W    = 8,
    parameter int RF       = 10,
    parameter int SOC_W    = 16,
    parameter int FRAC_W   = 8,
    parameter int GAIN_W   = 16,
    parameter int CAP_GAIN = 64,
    localparam int IDX_W   = $clog2(K),
    localparam int SEL_W   = $clog2(K) + 1
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    init_i,
    input  logic                    wr_en_i,
    input  logic [IDX_W-1:0]        wr_idx_i,
    input  logic [SOC_W-1:0]        wr_data_i,
    input  logic                    sample_vld_i,
    input  logic signed [CUR_W-1:0] i_string_i,
    input  logic signed [CUR_W-1:0] i_bal_i,
    input  logic signed [CUR_W-1:0] i_mod_i,
    input  logic [SEL_W-1:0]        sel_i,
    input  logic [EFF_W-1:0]        eff_i,
    output logic [K*SOC_W-1:0]      soc_o
);
    localparam int IC_W = CUR_W + 3;

    logic signed [CUR_W:0] share;
    logic [K*IC_W-1:0]     icur;
    logic                  step;

    assign step = sample_vld_i && !init_i;

    cct_share #(.K(K), .CUR_W(CUR_W), .EFF_W(EFF_W), .RF(RF)) u_share (
        .i_bal_i (i_bal_i),
        .eff_i   (eff_i),
        .share_o (share)
    );

    cct_cell_cur #(.K(K), .CUR_W(CUR_W), .SEL_W(SEL_W), .IC_W(IC_W)) u_cur (
        .i_string_i (i_string_i),
        .i_bal_i    (i_bal_i),
        .i_mod_i    (i_mod_i),
        .share_i    (share),
        .sel_i      (sel_i),
        .icur_o     (icur)
    );

    for (genvar g = 0; g < K; g++) begin : g_soc
        logic load;
        assign load = init_i && wr_en_i && (wr_idx_i == IDX_W'(g));
        cct_soc_reg #(
            .IC_W(IC_W), .SOC_W(SOC_W), .FRAC_W(FRAC_W),
            .GAIN_W(GAIN_W), .CAP_GAIN(CAP_GAIN)
        ) u_reg (
            .clk_i       (clk_i),
            .rst_i       (rst_i),
            .load_i      (load),
            .load_data_i (wr_data_i),
            .step_i      (step),
            .icur_i      (icur[g*IC_W +: IC_W]),
            .soc_o       (soc_o[g*SOC_W +: SOC_W])
        );
    end
endmodule

// File: rtl/cct_tracker_chk.sv
module cct_tracker_chk #(
    parameter int K        = 4,
    parameter int CUR_W    = 12,
    parameter int EFF_W    = 8,
    parameter int RF       = 10,
    parameter int SOC_W    = 16,
    parameter int FRAC_W   = 8,
    parameter int GAIN_W   = 16,
    parameter int CAP_GAIN = 64,
    localparam int IDX_W   = $clog2(K),
    localparam int SEL_W   = $clog2(K) + 1
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic                    init_i,
    input logic                    wr_en_i,
    input logic [IDX_W-1:0]        wr_idx_i,
    input logic [SOC_W-1:0]        wr_data_i,
    input logic                    sample_vld_i,
    input logic signed [CUR_W-1:0] i_string_i,
    input logic signed [CUR_W-1:0] i_bal_i,
    input logic signed [CUR_W-1:0] i_mod_i,
    input logic [SEL_W-1:0]        sel_i,
    input logic [EFF_W-1:0]        eff_i,
    input logic [K*SOC_W-1:0]      soc_o
);
    logic             wr_q, gain_q;
    logic [IDX_W-1:0] widx_q, gidx_q, sel_idx;
    logic [SOC_W-1:0] wdata_q, gprev_q;

    assign sel_idx = (sel_i < SEL_W'(K)) ? sel_i[IDX_W-1:0] : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wr_q   <= 1'b0;
            gain_q <= 1'b0;
        end else begin
            wr_q   <= init_i && wr_en_i;
            gain_q <= sample_vld_i && !init_i && (sel_i < SEL_W'(K)) && !i_bal_i[CUR_W-1];
        end
        widx_q  <= wr_idx_i;
        wdata_q <= wr_data_i;
        gidx_q  <= sel_idx;
        gprev_q <= soc_o[sel_idx*SOC_W +: SOC_W];
    end

    a_r1_reset_zero: assert property (@(posedge clk_i) rst_i |=> (soc_o == '0));

    a_r2_write_loads: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_q |-> (soc_o[widx_q*SOC_W +: SOC_W] == wdata_q));

    a_r3_init_pause: assert property (@(posedge clk_i) disable iff (rst_i)
        (init_i && !wr_en_i) |=> $stable(soc_o));

    a_r4_hold_no_sample: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sample_vld_i && !init_i) |=> $stable(soc_o));

    a_r5_bypassed_gains: assert property (@(posedge clk_i) disable iff (rst_i)
        gain_q |-> (soc_o[gidx_q*SOC_W +: SOC_W] >= gprev_q));
endmodule

bind cct_tracker cct_tracker_chk #(
    .K(K), .CUR_W(CUR_W), .EFF_W(EFF_W), .RF(RF), .SOC_W(SOC_W),
    .FRAC_W(FRAC_W), .GAIN_W(GAIN_W), .CAP_GAIN(CAP_GAIN)
) u_chk (.*);

// File: tb/tb_cct_tracker.sv
module tb_cct_tracker;
    localparam int K = 4, CUR_W = 12, EFF_W = 8, RF = 10;
    localparam int SOC_W = 16, FRAC_W = 8, GAIN_W = 16, CAP_GAIN = 64;
    localparam int RECIP = (1 << RF) / (K - 1);
    localparam longint ACC_MAX = (longint'(1) << (SOC_W + FRAC_W)) - 1;
    localparam int NV = 8;
    // istr, ibal, imod, sel, eff
    localparam int VEC [NV][5] = '{
        '{  100,   200,   0, 0, 200},
        '{ -300,   150,   5, 1, 255},
        '{   50,  -400,   0, 2, 128},
        '{-1000,     0, -20, 3, 200},
        '{   20,   500,  10, 5, 200},
        '{    0,  -777,   0, 1, 230},
        '{ 2047,  2047,   0, 3, 255},
        '{-2048, -2048,   0, 0, 255}
    };

    logic clk = 0, rst = 1, init = 0, wr_en = 0, vld = 0;
    logic [1:0] wr_idx = 0;
    logic [SOC_W-1:0] wr_data = 0;
    logic signed [CUR_W-1:0] istr = 0, ibal = 0, imod = 0;
    logic [2:0] sel = 0;
    logic [EFF_W-1:0] eff = 0;
    logic [K*SOC_W-1:0] soc;

    int tests = 0, fails = 0;
    longint acc_m [K];

    always #5 clk = ~clk;

    cct_tracker dut (
        .clk_i(clk), .rst_i(rst), .init_i(init), .wr_en_i(wr_en),
        .wr_idx_i(wr_idx), .wr_data_i(wr_data), .sample_vld_i(vld),
        .i_string_i(istr), .i_bal_i(ibal), .i_mod_i(imod), .sel_i(sel),
        .eff_i(eff), .soc_o(soc)
    );

    task automatic check(input string tag, input int c, input longint exp);
        longint act;
        act = longint'(soc[c*SOC_W +: SOC_W]);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s cell %0d: actual %0d expected %0d", tag, c, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < K; c++) check(tag, c, acc_m[c] >>> FRAC_W);
    endtask

    task automatic load(input int c, input int val);
        @(negedge clk);
        init = 1; wr_en = 1; wr_idx = 2'(c); wr_data = SOC_W'(val);
        @(negedge clk);
        wr_en = 0; init = 0;
        acc_m[c] = longint'(val) << FRAC_W;
    endtask

    function automatic longint cur_m(input int c, input int s, input int b,
                                     input int m, input int sl, input int e);
        longint sh;
        sh = (longint'(b) * e * RECIP) / (longint'(1) << (EFF_W + RF));
        if (sl >= K) return s + m;
        if (sl == c) return -b;
        return s + sh + m;
    endfunction

    task automatic sample(input int s, input int b, input int m, input int sl, input int e);
        longint n;
        @(negedge clk);
        istr = CUR_W'(s); ibal = CUR_W'(b); imod = CUR_W'(m);
        sel = 3'(sl); eff = EFF_W'(e); vld = 1;
        @(negedge clk);
        vld = 0;
        for (int c = 0; c < K; c++) begin
            n = acc_m[c] - cur_m(c, s, b, m, sl, e) * CAP_GAIN;
            if (n < 0) n = 0;
            if (n > ACC_MAX) n = ACC_MAX;
            acc_m[c] = n;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < K; c++) acc_m[c] = 0;
        repeat (3) @(negedge clk);
        check_all("R1 during reset");
        rst = 0;
        @(negedge clk);
        check_all("R1 after reset");

        load(0, 30000); load(1, 31000); load(2, 32000); load(3, 33000);
        check_all("R2 initial load");

        for (int v = 0; v < NV; v++) begin
            sample(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
            if (VEC[v][3] >= K) check_all("R7 no cell selected");
            else begin
                for (int c = 0; c < K; c++)
                    check((c == VEC[v][3]) ? "R5 bypassed cell" : "R6 R8 string cell",
                          c, acc_m[c] >>> FRAC_W);
            end
        end

        @(negedge clk);
        istr = 12'sd2000; sel = 3'd7; vld = 0;
        repeat (3) @(negedge clk);
        check_all("R4 no sample strobe");

        @(negedge clk);
        init = 1; vld = 1;
        repeat (3) @(negedge clk);
        init = 0; vld = 0;
        check_all("R3 init suspends");

        load(2, 12345);
        check_all("R2 single write");

        for (int c = 0; c < K; c++) load(c, 300 + c);
        sample(2047, 0, 0, 7, 0);
        check_all("R9 floor clamp");

        for (int c = 0; c < K; c++) load(c, 65300 + c);
        sample(-2048, 0, 0, 7, 0);
        check_all("R10 ceiling clamp");

        sample(-10, 0, 0, 7, 0);
        check_all("R10 stays at full");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule